// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single-byte host requests into timed cycles on an 8-bit asynchronous NAND flash bus. A host presents a request with a direction, an address and a write byte. For a write, two chosen address bits decide the cycle type. One bit marks a command byte, which raises the command latch enable. The other marks an address byte, which raises the address latch enable. With neither bit set the byte is plain data. A read fetches one byte from the flash data pins.

Each access runs through four phases: setup, strobe, hold and a turnaround gap. The length of each phase comes from a packed 32-bit timing word, which the block captures when it accepts the request. The block also passes the flash ready/busy pin to a status byte through a synchronizer, and drives a write-protect pin from the chip-select input. To read the flash status, the host issues a status command byte, polls the ready bit, and then reads one byte.

Top module: `nandseq_top`

## Requirements
- R1: A write whose address has bit CLE_BIT (default 4) set is a command cycle: nandCle is high from the first setup cycle to the last hold cycle and nandAle stays low. When both mask bits are set, the command type wins.
- R2: A write with bit CLE_BIT clear and bit ALE_BIT (default 3) set is an address cycle: nandAle is high from setup through hold and nandCle stays low.
- R3: Every write drives the latched byte on nandDataOut with nandDataOe high from setup through hold. A read never raises nandDataOe.
- R4: Phase lengths come from the timing word, and a field value N gives N+1 cycles. The fields are: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4] and turnaround [3:2]. Bits 31:30 and 1:0 have no effect, and bus size 0 is the 8-bit bus.
- R5: nandWeN (on writes) and nandReN (on reads) are low only during the strobe phase, and the two are never low together.
- R6: nandCeN is low from the first setup cycle to the last hold cycle, and high otherwise.
- R7: On a read, the flash byte is captured on the clock edge that ends the strobe phase. rdData holds it from the next cycle on, and rdValid is high for exactly that first hold cycle.
- R8: busy rises in the cycle after a request is accepted and falls after the last turnaround cycle. A request is accepted when reqValid is high while busy is low. Requests presented while busy is high are ignored.
- R9: The timing word is sampled when a request is accepted. Changes during the access do not affect it.
- R10: statusOut[0] follows nandRdy (1 = ready) two clock edges later. statusOut[7:1] is zero.
- R11: nandWp follows chipSel one clock edge later: high while selected, low when deselected.
- R12: In reset, nandCeN, nandWeN and nandReN are high; nandCle, nandAle, nandDataOe, busy, rdValid, nandWp and statusOut are low; rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Packed timing word |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Host address; carries the command and address mask bits |
| reqWdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | One-cycle pulse when rdData updates |
| statusOut | output | 8 | Status byte; bit 0 = flash ready |
| chipSel | input | 1 | Chip selected |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandDataOut | output | 8 | Byte driven to the flash |
| nandDataOe | output | 1 | Output enable for nandDataOut |
| nandDataIn | input | 8 | Byte from the flash |
| nandRdy | input | 1 | Flash ready/busy pin |
| nandWp | output | 1 | Write protect |

## Verification
The bench covers these corner cases:

- All-zero timing fields, where every phase lasts one cycle. A design that treats zero as "skip" would shorten or drop a strobe.
- All-ones timing fields, where a field that is too narrow would wrap and shorten the strobe.
- A request presented in mid-access. A sequencer that accepts it would start a second strobe or corrupt the cycle-type lines.
- Rewriting the timing word during an access. A design that reads the word live would stretch or cut the current strobe.
- An address with both mask bits set, which tests the command-first priority.
- reqValid held high back to back, which tests that the next access starts in the cycle after the turnaround ends.
- Read capture at the exact end of the strobe. Sampling one cycle early or late returns the wrong byte.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;

  localparam int CFG_W   = 32;
  localparam int CNT_W   = 6;

  localparam int WS_LSB  = 26;
  localparam int WS_W    = 4;
  localparam int WST_LSB = 20;
  localparam int WST_W   = 6;
  localparam int WH_LSB  = 17;
  localparam int WH_W    = 3;
  localparam int RS_LSB  = 13;
  localparam int RS_W    = 4;
  localparam int RST_LSB = 7;
  localparam int RST_W   = 6;
  localparam int RH_LSB  = 4;
  localparam int RH_W    = 3;
  localparam int TA_LSB  = 2;
  localparam int TA_W    = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_TURN
  } phase_t;

  typedef enum logic [1:0] {
    KIND_READ, KIND_CMD, KIND_ADDR, KIND_DATA
  } kind_t;

  typedef struct packed {
    logic [WS_W-1:0]  wrSetup;
    logic [WST_W-1:0] wrStrobe;
    logic [WH_W-1:0]  wrHold;
    logic [RS_W-1:0]  rdSetup;
    logic [RST_W-1:0] rdStrobe;
    logic [RH_W-1:0]  rdHold;
    logic [TA_W-1:0]  turn;
  } timing_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // request accepted this cycle
    logic drive;    // setup, strobe or hold phase
    logic capture;  // last strobe cycle of a read
  } strobe_t;

  function automatic timing_t unpackTiming(input logic [CFG_W-1:0] w);
    timing_t t;
    t.wrSetup  = w[WS_LSB  +: WS_W];
    t.wrStrobe = w[WST_LSB +: WST_W];
    t.wrHold   = w[WH_LSB  +: WH_W];
    t.rdSetup  = w[RS_LSB  +: RS_W];
    t.rdStrobe = w[RST_LSB +: RST_W];
    t.rdHold   = w[RH_LSB  +: RH_W];
    t.turn     = w[TA_LSB  +: TA_W];
    return t;
  endfunction

endpackage

// File: rtl/nandseq_ctrl.sv
module nandseq_ctrl
  import nandseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CFG_W-1:0] cfgWord,
  output strobe_t          stb,
  output logic             busy,
  output logic             ceN,
  output logic             weN,
  output logic             reN
);

  phase_t             phase;
  phase_t             phaseNext;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   limit;
  logic               isWr;
  timing_t            tim;
  logic               accept;
  logic               last;
  logic               inAccess;

  assign accept = reqValid && (phase == PH_IDLE);

  always_comb begin
    limit = '0;
    unique case (phase)
      PH_SETUP:  limit = isWr ? CNT_W'(tim.wrSetup)  : CNT_W'(tim.rdSetup);
      PH_STROBE: limit = isWr ? CNT_W'(tim.wrStrobe) : CNT_W'(tim.rdStrobe);
      PH_HOLD:   limit = isWr ? CNT_W'(tim.wrHold)   : CNT_W'(tim.rdHold);
      PH_TURN:   limit = CNT_W'(tim.turn);
      default:   limit = '0;
    endcase
  end

  assign last = (cnt == limit);

  always_comb begin
    unique case (phase)
      PH_SETUP:  phaseNext = PH_STROBE;
      PH_STROBE: phaseNext = PH_HOLD;
      PH_HOLD:   phaseNext = PH_TURN;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      tim   <= '0;
    end else if (accept) begin
      phase <= PH_SETUP;
      cnt   <= '0;
      isWr  <= reqWrite;
      tim   <= unpackTiming(cfgWord);
    end else if (phase != PH_IDLE) begin
      if (last) begin
        phase <= phaseNext;
        cnt   <= '0;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assign inAccess    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign busy        = (phase != PH_IDLE);
  assign ceN         = !inAccess;
  assign weN         = !((phase == PH_STROBE) && isWr);
  assign reN         = !((phase == PH_STROBE) && !isWr);
  assign stb.load    = accept;
  assign stb.drive   = inAccess;
  assign stb.capture = (phase == PH_STROBE) && last && !isWr;

endmodule

// File: rtl/nandseq_dpath.sv
module nandseq_dpath
  import nandseq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] nandDataIn,
  input  logic              nandRdy,
  input  logic              chipSel,
  output logic              nandCle,
  output logic              nandAle,
  output logic [DATA_W-1:0] nandDataOut,
  output logic              nandDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] statusOut,
  output logic              nandWp
);

  localparam int SYNC_N = 2;

  kind_t             kind;
  kind_t             kindIn;
  logic [DATA_W-1:0] wdataReg;
  logic [SYNC_N-1:0] rdySync;

  always_comb begin
    if (!reqWrite)             kindIn = KIND_READ;
    else if (reqAddr[CLE_BIT]) kindIn = KIND_CMD;
    else if (reqAddr[ALE_BIT]) kindIn = KIND_ADDR;
    else                       kindIn = KIND_DATA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind     <= KIND_READ;
      wdataReg <= '0;
    end else if (stb.load) begin
      kind     <= kindIn;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.capture;
      if (stb.capture) rdData <= nandDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdySync <= '0;
      nandWp  <= 1'b0;
    end else begin
      rdySync <= {rdySync[SYNC_N-2:0], nandRdy};
      nandWp  <= chipSel;
    end
  end

  assign nandCle     = stb.drive && (kind == KIND_CMD);
  assign nandAle     = stb.drive && (kind == KIND_ADDR);
  assign nandDataOe  = stb.drive && (kind != KIND_READ);
  assign nandDataOut = wdataReg;
  assign statusOut   = {{(DATA_W-1){1'b0}}, rdySync[SYNC_N-1]};

endmodule

// File: rtl/nandseq_top.sv
module nandseq_top
  import nandseq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgWord,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              busy,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic [7:0]        statusOut,
  input  logic              chipSel,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDataOut,
  output logic              nandDataOe,
  input  logic [7:0]        nandDataIn,
  input  logic              nandRdy,
  output logic              nandWp
);

  strobe_t stb;

  nandseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .cfgWord  (cfgWord),
    .stb      (stb),
    .busy     (busy),
    .ceN      (nandCeN),
    .weN      (nandWeN),
    .reN      (nandReN)
  );

  nandseq_dpath #(
    .ADDR_W  (ADDR_W),
    .CLE_BIT (CLE_BIT),
    .ALE_BIT (ALE_BIT),
    .DATA_W  (8)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .nandDataIn  (nandDataIn),
    .nandRdy     (nandRdy),
    .chipSel     (chipSel),
    .nandCle     (nandCle),
    .nandAle     (nandAle),
    .nandDataOut (nandDataOut),
    .nandDataOe  (nandDataOe),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .statusOut   (statusOut),
    .nandWp      (nandWp)
  );

endmodule

// File: rtl/nandseq_chk.sv
module nandseq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              rdValid,
  input logic [7:0]        statusOut,
  input logic              chipSel,
  input logic              nandCeN,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              nandDataOe,
  input logic              nandWp
);

  p_cle_ale_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  p_oe_in_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    nandDataOe |-> !nandCeN);

  p_we_re_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  p_strobe_needs_ce_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

  p_rdvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (nandCeN && nandWeN && nandReN));

  p_status_upper_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7:1] == 7'd0);

  p_wp_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (nandWp == $past(chipSel)));

endmodule

bind nandseq_top nandseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busy       (busy),
  .rdValid    (rdValid),
  .statusOut  (statusOut),
  .chipSel    (chipSel),
  .nandCeN    (nandCeN),
  .nandCle    (nandCle),
  .nandAle    (nandAle),
  .nandWeN    (nandWeN),
  .nandReN    (nandReN),
  .nandDataOe (nandDataOe),
  .nandWp     (nandWp)
);

// File: tb/tb_nandseq_top.sv
`timescale 1ns/1ps
module tb_nandseq_top;

  localparam logic [31:0] DEF_CFG = 32'h0432229C; // 1,3,1,1,5,1,3
  localparam logic [31:0] MAX_CFG = 32'h3FFFFFFC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = DEF_CFG;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        chipSel = 1'b0;
  logic [7:0]  nandDataIn = '0;
  logic        nandRdy = 1'b0;
  logic        busy, rdValid, nandCeN, nandCle, nandAle, nandWeN, nandReN;
  logic        nandDataOe, nandWp;
  logic [7:0]  rdData, statusOut, nandDataOut;

  nandseq_top dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .statusOut(statusOut),
    .chipSel(chipSel), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDataOut(nandDataOut),
    .nandDataOe(nandDataOe), .nandDataIn(nandDataIn), .nandRdy(nandRdy),
    .nandWp(nandWp)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;
  int weLow = 0;
  int reLow = 0;

  // behavioural reference model
  int   mPhase = 0;   // 0 idle 1 setup 2 strobe 3 hold 4 turn
  int   mLeft = 0;
  bit   mWr = 0;
  int   mKind = 0;    // 0 read 1 cmd 2 addr 3 data
  int   mLen[5][2];   // [phase][write]
  logic [7:0] mWdata = 0;
  logic [7:0] mRd = 0;
  bit   mRdV = 0;
  bit   mWp = 0;
  bit   mS1 = 0, mS2 = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mWr = 0; mKind = 0; mWdata = 0;
      mRd = 0; mRdV = 0; mWp = 0; mS1 = 0; mS2 = 0;
      started = 1;
    end else begin
      mRdV = 0;
      case (mPhase)
        0: if (reqValid) begin
             mWr = reqWrite;
             mKind = !reqWrite ? 0 : reqAddr[4] ? 1 : reqAddr[3] ? 2 : 3;
             mWdata = reqWdata;
             mLen[1][1] = (cfgWord >> 26) & 15;
             mLen[2][1] = (cfgWord >> 20) & 63;
             mLen[3][1] = (cfgWord >> 17) & 7;
             mLen[1][0] = (cfgWord >> 13) & 15;
             mLen[2][0] = (cfgWord >> 7) & 63;
             mLen[3][0] = (cfgWord >> 4) & 7;
             mLen[4][0] = (cfgWord >> 2) & 3;
             mLen[4][1] = mLen[4][0];
             mPhase = 1;
             mLeft = mLen[1][mWr];
           end
        default: begin
          if (mLeft == 0) begin
            if (mPhase == 2 && !mWr) begin mRd = nandDataIn; mRdV = 1; end
            mPhase = (mPhase == 4) ? 0 : mPhase + 1;
            if (mPhase != 0) mLeft = mLen[mPhase][mWr];
          end else mLeft = mLeft - 1;
        end
      endcase
      mS2 = mS1; mS1 = nandRdy;
      mWp = chipSel;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    bit acc;
    acc = (mPhase >= 1 && mPhase <= 3);
    if (!rstN) begin
      chk("R12", "reset pins", {nandCeN, nandWeN, nandReN, nandCle, nandAle,
          nandDataOe, busy, rdValid, nandWp}, 9'b111000000);
      chk("R12", "reset data", {rdData, statusOut}, 16'h0);
    end else begin
      chk("R6", "nandCeN", nandCeN, !acc);
      chk("R4/R5", "nandWeN", nandWeN, !(mPhase == 2 && mWr));
      chk("R4/R5", "nandReN", nandReN, !(mPhase == 2 && !mWr));
      chk("R1", "nandCle", nandCle, acc && mKind == 1);
      chk("R2", "nandAle", nandAle, acc && mKind == 2);
      chk("R3", "nandDataOe", nandDataOe, acc && mWr);
      if (acc && mWr) chk("R3", "nandDataOut", nandDataOut, mWdata);
      chk("R8", "busy", busy, mPhase != 0);
      chk("R7", "rdValid", rdValid, mRdV);
      chk("R7", "rdData", rdData, mRd);
      chk("R10", "statusOut", statusOut, {7'd0, mS2});
      chk("R11", "nandWp", nandWp, mWp);
      if (!nandWeN) weLow++;
      if (!nandReN) reLow++;
    end
  end

  task automatic doOp(input bit wr, input logic [7:0] addr, input logic [7:0] dat,
                      input logic [31:0] cfg);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = dat; cfgWord = cfg;
    @(negedge clk);
    reqValid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    chipSel = 1;
    // R1 command byte, default timing
    doOp(1, 8'h10, 8'h70, DEF_CFG);
    // R2 address byte
    doOp(1, 8'h08, 8'h12, DEF_CFG);
    // R3 data byte with all-zero fields (one-cycle phases); R4 strobe length
    weLow = 0;
    doOp(1, 8'h00, 8'h5A, 32'h0);
    chk("R4", "zero-field strobe cycles", weLow, 1);
    // R1 priority when both mask bits set
    doOp(1, 8'h18, 8'hC3, DEF_CFG);
    // R7 read with default timing, R4 read strobe = 6
    nandDataIn = 8'hA5; reLow = 0;
    doOp(0, 8'h00, 8'h00, DEF_CFG);
    chk("R4", "default read strobe cycles", reLow, 6);
    chk("R7", "read byte", rdData, 8'hA5);
    // R4 maximum fields; unused bits 31:30, 1:0 set
    nandDataIn = 8'h3C; reLow = 0;
    doOp(0, 8'h00, 8'h00, 32'hFFFFFFFF);
    chk("R4", "max read strobe cycles", reLow, 64);
    weLow = 0;
    doOp(1, 8'h00, 8'h99, MAX_CFG);
    chk("R4", "max write strobe cycles", weLow, 64);
    // R8 request while busy is ignored
    reLow = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 8'h08; reqWdata = 8'h44; cfgWord = DEF_CFG;
    @(negedge clk);
    reqValid = 0;
    repeat (2) @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 8'h10;
    @(negedge clk);
    reqValid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R8", "ignored read strobe cycles", reLow, 0);
    // R9 timing word changed mid-access
    weLow = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 8'h00; reqWdata = 8'h21; cfgWord = DEF_CFG;
    @(negedge clk);
    reqValid = 0; cfgWord = 32'h0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R9", "strobe cycles after cfg change", weLow, 4);
    // R8 back-to-back with reqValid held
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 8'h00; reqWdata = 8'h0F; cfgWord = 32'h0;
    repeat (14) @(negedge clk);
    reqValid = 0;
    while (busy) @(negedge clk);
    // R10/R11 ready and chip select
    nandRdy = 1; repeat (3) @(negedge clk);
    chk("R10", "ready seen", statusOut, 8'h01);
    chipSel = 0; nandRdy = 0; repeat (3) @(negedge clk);
    chk("R11", "wp low when deselected", nandWp, 0);
    chipSel = 1;
    // status flow: command, poll ready, read
    doOp(1, 8'h10, 8'h70, DEF_CFG);
    nandRdy = 1;
    while (statusOut[0] !== 1'b1) @(negedge clk);
    nandDataIn = 8'hE0;
    doOp(0, 8'h00, 8'h00, DEF_CFG);
    chk("R7", "status byte read", rdData, 8'hE0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule